// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is the control engine of one DMA channel. Software writes a chain of transfer descriptors into memory and then pulses `start` with the address of the first descriptor. Each descriptor is six 32-bit words. The sequencer reads the words one by one over a single request/ready memory port. It loads the working source and destination addresses from them, and then moves the data one word at a time: a read from the source, then a write to the destination. Per-descriptor control bits can suppress the read (zeros are written instead) or the write (the destination address still advances). They can also select whether each address increments, and they can switch on a two-dimensional mode. In that mode a number of rows are copied, and a signed stride is added to each address between rows.

When a descriptor finishes, the channel raises its end flag, and raises its interrupt if the descriptor asks for one. It then follows the descriptor's link word. The chain stops when the link is zero or when the channel's global enable has been withdrawn. At that point the channel drops its active bit and reports itself paused. The fetched control words are brought out on read-only outputs, so that a register front end can mirror them. A synchronous channel reset returns the engine to idle at once, even in the middle of a chain.

Top module: `cbdma_seq`

## Requirements
- R1: After `rst_n` is released, the channel is idle. `mem_req`, `active`, `paused`, `end_flag` and `irq` are all low, and `cur_cb` is 0.
- R2: A `start` pulse while `chan_en` is low is ignored. No memory request is issued, `active` stays low and `cur_cb` is not loaded.
- R3: A descriptor at address A is read as six words, from A+0 up to A+20 in steps of 4. In that order the words are: control word, source address, destination address, length, stride and link. The control word, length, stride and link are held on `sh_info`, `sh_len`, `sh_stride` and `sh_next`.
- R4: In the plain mode (control bit 1 = 0), the length word is a byte count, and a partial last word counts as a whole word. For each word the channel reads the source and then writes that data to the destination. After each word the source address grows by 4 if control bit 8 is set, and the destination address grows by 4 if control bit 4 is set. Otherwise each address stays fixed. The live addresses are shown on `cur_src` and `cur_dst`.
- R5: If control bit 11 is set, no source read takes place and the value 0 is written to the destination for every word.
- R6: If control bit 7 is set, no destination write takes place. The destination address still advances as R4 says.
- R7: If control bit 1 is set, length bits [29:16] give the number of rows and bits [15:0] give the bytes in each row. After every row except the last, the signed value in stride bits [15:0] is added to the source address and the signed value in stride bits [31:16] is added to the destination address.
- R8: At the end of each descriptor `end_flag` is set. If control bit 0 is set, `irq` is set as well. Both flags stay set until a channel reset.
- R9: After each descriptor, `cur_cb` takes the link word. The next descriptor is fetched only if `chan_en` is high and the link is nonzero. A descriptor that has already started always runs to its end.
- R10: When the chain stops, `active` falls and `paused` is set. A start with descriptor address 0 stops in this way without any fetch.
- R11: A cycle with `chan_reset` high returns the channel to idle by the next cycle. It drops `mem_req` and clears `active`, `paused`, `end_flag`, `irq` and `cur_cb`. No further memory writes follow.
- R12: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until a cycle in which `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_reset | input | 1 | Synchronous channel reset, forces idle |
| chan_en | input | 1 | Global enable bit of this channel |
| start | input | 1 | Start pulse |
| start_cb | input | 32 | First descriptor address, sampled with `start` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Access completes in this cycle |
| active | output | 1 | Chain in progress |
| paused | output | 1 | Chain has stopped |
| end_flag | output | 1 | A descriptor has completed |
| irq | output | 1 | Interrupt flag and channel interrupt line |
| cur_cb | output | 32 | Current descriptor address |
| cur_src | output | 32 | Live source address |
| cur_dst | output | 32 | Live destination address |
| sh_info | output | 32 | Fetched control word |
| sh_len | output | 32 | Fetched length word |
| sh_stride | output | 32 | Fetched stride word |
| sh_next | output | 32 | Fetched link word |

## Verification
The bench targets these corner cases:

- A length that is not a multiple of four. A design that truncates it would leave the final partial word uncopied.
- A two-dimensional copy with a negative destination stride. A design that sign-extends wrongly, or applies the stride after the last row as well, would write to the wrong rows or leave the wrong final addresses.
- Enable withdrawn in the middle of a chain. A design that checks enable only at start would fetch the second descriptor, and one that checks it per word would cut the first descriptor short.
- A channel reset in the middle of a transfer. A design that only stops at a descriptor boundary would keep writing after the reset.
- Write suppression. A design that skips the address step along with the write would leave the destination address unmoved.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CB_WORDS = 6;
    localparam int unsigned IDX_W    = $clog2(CB_WORDS);

    typedef logic [WORD_W-1:0] word_t;

    // control word bit positions (decoded from memory-resident descriptors)
    localparam int unsigned TI_IRQ  = 0;
    localparam int unsigned TI_2D   = 1;
    localparam int unsigned TI_DINC = 4;
    localparam int unsigned TI_DIGN = 7;
    localparam int unsigned TI_SINC = 8;
    localparam int unsigned TI_SIGN = 11;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHK,
        S_FETCH,
        S_SETUP,
        S_RD,
        S_WR,
        S_STEP,
        S_DONE
    } st_e;

    typedef struct packed {
        st_e              st;
        logic [IDX_W-1:0] idx;
        word_t            cb;
        word_t            info;
        word_t            src;
        word_t            dst;
        word_t            len;
        word_t            stride;
        word_t            nxt;
        word_t            xcnt;
        word_t            ycnt;
        word_t            rowlen;
        word_t            data;
        logic             active;
        logic             paused;
        logic             endf;
        logic             intf;
    } seq_t;
endpackage

// File: rtl/cbdma_len_cnt.sv
module cbdma_len_cnt
    import cbdma_pkg::*;
#(
    parameter int unsigned WB = 4
) (
    input  word_t xcnt,
    input  word_t ycnt,
    input  word_t rowlen,
    output word_t x_next,
    output word_t y_next,
    output logic  row_end,
    output logic  desc_end
);
    localparam word_t STEP_B = word_t'(WB);

    word_t x_after;
    word_t y_after;

    // a partial last word consumes the rest of the row
    assign x_after  = (xcnt <= STEP_B) ? '0 : (xcnt - STEP_B);
    assign row_end  = (x_after == '0);
    assign y_after  = row_end ? (ycnt - word_t'(1)) : ycnt;
    assign desc_end = row_end && (y_after == '0);
    assign x_next   = row_end ? rowlen : x_after;
    assign y_next   = y_after;
endmodule

// File: rtl/cbdma_addr_step.sv
module cbdma_addr_step
    import cbdma_pkg::*;
#(
    parameter int unsigned WB       = 4,
    parameter int unsigned STRIDE_W = 16
) (
    input  word_t               addr,
    input  logic                inc,
    input  logic                apply_stride,
    input  logic [STRIDE_W-1:0] stride,
    output word_t               next
);
    localparam word_t STEP_B = word_t'(WB);

    word_t stride_x;
    word_t inc_v;

    assign stride_x = {{(WORD_W-STRIDE_W){stride[STRIDE_W-1]}}, stride};
    assign inc_v    = inc ? STEP_B : '0;
    assign next     = addr + inc_v + (apply_stride ? stride_x : '0);
endmodule

// File: rtl/cbdma_seq.sv
module cbdma_seq
    import cbdma_pkg::*;
#(
    parameter int unsigned ROWS_W   = 14,
    parameter int unsigned COLS_W   = 16,
    parameter int unsigned STRIDE_W = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  chan_reset,
    input  logic  chan_en,
    input  logic  start,
    input  word_t start_cb,
    output logic  mem_req,
    output logic  mem_we,
    output word_t mem_addr,
    output word_t mem_wdata,
    input  word_t mem_rdata,
    input  logic  mem_ready,
    output logic  active,
    output logic  paused,
    output logic  end_flag,
    output logic  irq,
    output word_t cur_cb,
    output word_t cur_src,
    output word_t cur_dst,
    output word_t sh_info,
    output word_t sh_len,
    output word_t sh_stride,
    output word_t sh_next
);
    localparam int unsigned WB       = WORD_W / 8;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CB_WORDS - 1);
    localparam seq_t SEQ_RST = '0;

    seq_t q, d;

    // length bookkeeping
    word_t x_nxt, y_nxt;
    logic  row_end, desc_end;

    cbdma_len_cnt #(.WB(WB)) u_len (
        .xcnt    (q.xcnt),
        .ycnt    (q.ycnt),
        .rowlen  (q.rowlen),
        .x_next  (x_nxt),
        .y_next  (y_nxt),
        .row_end (row_end),
        .desc_end(desc_end)
    );

    // address steppers: index 0 source, index 1 destination
    word_t               step_cur [2];
    word_t               step_nxt [2];
    logic                step_inc [2];
    logic [STRIDE_W-1:0] step_str [2];

    assign step_cur[0] = q.src;
    assign step_cur[1] = q.dst;
    assign step_inc[0] = q.info[TI_SINC];
    assign step_inc[1] = q.info[TI_DINC];
    assign step_str[0] = q.info[TI_2D] ? q.stride[STRIDE_W-1:0] : '0;
    assign step_str[1] = q.info[TI_2D] ? q.stride[WORD_W-1 -: STRIDE_W] : '0;

    for (genvar g = 0; g < 2; g++) begin : g_step
        cbdma_addr_step #(.WB(WB), .STRIDE_W(STRIDE_W)) u_step (
            .addr        (step_cur[g]),
            .inc         (step_inc[g]),
            .apply_stride(row_end && !desc_end),
            .stride      (step_str[g]),
            .next        (step_nxt[g])
        );
    end

    word_t rows_w, cols_w;
    assign rows_w = word_t'(q.len[COLS_W +: ROWS_W]);
    assign cols_w = word_t'(q.len[COLS_W-1:0]);

    // first action of every word, chosen by the suppression bits
    function automatic st_e word_start(input word_t ti);
        if (!ti[TI_SIGN])      return S_RD;
        else if (!ti[TI_DIGN]) return S_WR;
        else                   return S_STEP;
    endfunction

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.st)
            S_IDLE: begin
                if (start && chan_en) begin
                    d.active = 1'b1;
                    d.paused = 1'b0;
                    d.cb     = start_cb;
                    d.st     = S_CHK;
                end
            end
            S_CHK: begin
                if (chan_en && (q.cb != '0)) begin
                    d.idx = '0;
                    d.st  = S_FETCH;
                end else begin
                    d.active = 1'b0;
                    d.paused = 1'b1;
                    d.st     = S_IDLE;
                end
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.cb + (word_t'(q.idx) << 2);
                if (mem_ready) begin
                    case (q.idx)
                        3'd0:    d.info   = mem_rdata;
                        3'd1:    d.src    = mem_rdata;
                        3'd2:    d.dst    = mem_rdata;
                        3'd3:    d.len    = mem_rdata;
                        3'd4:    d.stride = mem_rdata;
                        default: d.nxt    = mem_rdata;
                    endcase
                    if (q.idx == LAST_IDX) d.st  = S_SETUP;
                    else                   d.idx = q.idx + 1'b1;
                end
            end
            S_SETUP: begin
                if (q.info[TI_2D]) begin
                    d.ycnt   = rows_w;
                    d.xcnt   = cols_w;
                    d.rowlen = cols_w;
                    d.st     = ((rows_w == '0) || (cols_w == '0)) ? S_DONE
                                                                  : word_start(q.info);
                end else begin
                    d.ycnt   = word_t'(1);
                    d.xcnt   = q.len;
                    d.rowlen = q.len;
                    d.st     = (q.len == '0) ? S_DONE : word_start(q.info);
                end
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = q.src;
                if (mem_ready) begin
                    d.data = mem_rdata;
                    d.st   = q.info[TI_DIGN] ? S_STEP : S_WR;
                end
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.dst;
                mem_wdata = q.info[TI_SIGN] ? '0 : q.data;
                if (mem_ready) d.st = S_STEP;
            end
            S_STEP: begin
                d.src  = step_nxt[0];
                d.dst  = step_nxt[1];
                d.xcnt = x_nxt;
                d.ycnt = y_nxt;
                d.st   = desc_end ? S_DONE : word_start(q.info);
            end
            S_DONE: begin
                d.endf = 1'b1;
                if (q.info[TI_IRQ]) d.intf = 1'b1;
                d.cb = q.nxt;
                d.st = S_CHK;
            end
            default: d = SEQ_RST;
        endcase
        if (chan_reset) d = SEQ_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign active    = q.active;
    assign paused    = q.paused;
    assign end_flag  = q.endf;
    assign irq       = q.intf;
    assign cur_cb    = q.cb;
    assign cur_src   = q.src;
    assign cur_dst   = q.dst;
    assign sh_info   = q.info;
    assign sh_len    = q.len;
    assign sh_stride = q.stride;
    assign sh_next   = q.nxt;
endmodule

// File: rtl/cbdma_seq_chk.sv
module cbdma_seq_chk
    import cbdma_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  chan_reset,
    input logic  chan_en,
    input logic  start,
    input logic  mem_req,
    input logic  mem_we,
    input word_t mem_addr,
    input word_t mem_wdata,
    input logic  mem_ready,
    input logic  active,
    input logic  paused,
    input logic  end_flag,
    input logic  irq
);
    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || chan_reset)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata));

    // R2
    no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n || chan_reset)
        !active && start && !chan_en |=> !mem_req && !active);

    // R11
    chan_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_reset |=> !active && !mem_req && !end_flag && !irq && !paused);

    // R8
    irq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> end_flag);

    // R10
    stop_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) && !$past(chan_reset) |-> paused);
endmodule

bind cbdma_seq cbdma_seq_chk u_chk (.*);

// File: tb/cbdma_seq_tb.sv
module cbdma_seq_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_reset = 1'b0;
    logic        chan_en = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_cb = '0;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        active, paused, end_flag, irq;
    logic [31:0] cur_cb, cur_src, cur_dst, sh_info, sh_len, sh_stride, sh_next;

    logic [31:0] mem [0:511];
    logic [3:0]  rcnt = '0;
    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;

    always #(CLK_P/2) clk = ~clk;

    cbdma_seq dut_i (
        .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset), .chan_en(chan_en),
        .start(start), .start_cb(start_cb),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .active(active), .paused(paused), .end_flag(end_flag), .irq(irq),
        .cur_cb(cur_cb), .cur_src(cur_src), .cur_dst(cur_dst),
        .sh_info(sh_info), .sh_len(sh_len), .sh_stride(sh_stride), .sh_next(sh_next)
    );

    // memory model: one wait cycle in every four
    assign mem_ready = mem_req && (rcnt[1:0] != 2'd2);
    assign mem_rdata = mem[mem_addr[10:2]];

    always @(posedge clk) begin
        rcnt <= rcnt + 4'd1;
        if (mem_req && mem_we && mem_ready) mem[mem_addr[10:2]] <= mem_wdata;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            $display("FAIL watchdog: run hung, act=%0d exp=0", cyc);
            checks = checks + 1;
            fails  = fails + 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic fill(input int base, input int n, input logic [31:0] seed);
        for (int i = 0; i < n; i++) mem[(base >> 2) + i] <= seed + 32'(i);
        @(negedge clk);
    endtask

    task automatic put_cb(input int a, input logic [31:0] ti, input logic [31:0] s,
                          input logic [31:0] dd, input logic [31:0] l,
                          input logic [31:0] st, input logic [31:0] nx);
        mem[(a >> 2) + 0] <= ti;
        mem[(a >> 2) + 1] <= s;
        mem[(a >> 2) + 2] <= dd;
        mem[(a >> 2) + 3] <= l;
        mem[(a >> 2) + 4] <= st;
        mem[(a >> 2) + 5] <= nx;
        @(negedge clk);
    endtask

    task automatic kick(input logic [31:0] cb);
        @(negedge clk);
        start    = 1'b1;
        start_cb = cb;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input logic [31:0] cb);
        kick(cb);
        for (int i = 0; i < 4000 && active; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clr();
        @(negedge clk);
        chan_reset = 1'b1;
        @(negedge clk);
        chan_reset = 1'b0;
    endtask

    function automatic logic [31:0] rd(input int a);
        return mem[a >> 2];
    endfunction

    task automatic t_reset();
        eq("R1 active", {31'd0, active}, 32'd0);
        eq("R1 paused", {31'd0, paused}, 32'd0);
        eq("R1 end_flag", {31'd0, end_flag}, 32'd0);
        eq("R1 irq", {31'd0, irq}, 32'd0);
        eq("R1 mem_req", {31'd0, mem_req}, 32'd0);
        eq("R1 cur_cb", cur_cb, 32'd0);
    endtask

    task automatic t_disabled();
        bit seen = 0;
        put_cb(32'h40, 32'h110, 32'h200, 32'h400, 32'd4, 32'd0, 32'd0);
        chan_en = 1'b0;
        kick(32'h40);
        for (int i = 0; i < 20; i++) begin
            if (mem_req || active) seen = 1;
            @(negedge clk);
        end
        eq("R2 no request", {31'd0, seen}, 32'd0);
        eq("R2 cur_cb not loaded", cur_cb, 32'd0);
        chan_en = 1'b1;
    endtask

    task automatic t_single();
        fill(32'h200, 4, 32'hA000_0000);
        fill(32'h400, 4, 32'hEEEE_0000);
        put_cb(32'h40, 32'h110, 32'h200, 32'h400, 32'd12, 32'h0005_0007, 32'd0);
        run(32'h40);
        eq("R4 dst0", rd(32'h400), 32'hA000_0000);
        eq("R4 dst1", rd(32'h404), 32'hA000_0001);
        eq("R4 dst2", rd(32'h408), 32'hA000_0002);
        eq("R4 dst3 untouched", rd(32'h40C), 32'hEEEE_0003);
        eq("R4 cur_src", cur_src, 32'h20C);
        eq("R4 cur_dst", cur_dst, 32'h40C);
        eq("R3 sh_info", sh_info, 32'h110);
        eq("R3 sh_len", sh_len, 32'd12);
        eq("R3 sh_stride", sh_stride, 32'h0005_0007);
        eq("R3 sh_next", sh_next, 32'd0);
        eq("R8 end_flag", {31'd0, end_flag}, 32'd1);
        eq("R8 irq off", {31'd0, irq}, 32'd0);
        eq("R10 active", {31'd0, active}, 32'd0);
        eq("R10 paused", {31'd0, paused}, 32'd1);
        eq("R9 cur_cb", cur_cb, 32'd0);
        clr();
    endtask

    task automatic t_chain();
        fill(32'h200, 2, 32'h1111_0000);
        fill(32'h280, 1, 32'h2222_0000);
        fill(32'h400, 2, 32'hEEEE_0000);
        fill(32'h480, 1, 32'hEEEE_1000);
        put_cb(32'h40, 32'h110, 32'h200, 32'h400, 32'd8, 32'd0, 32'h60);
        put_cb(32'h60, 32'h111, 32'h280, 32'h480, 32'd4, 32'd0, 32'd0);
        run(32'h40);
        eq("R9 chain d1 w0", rd(32'h400), 32'h1111_0000);
        eq("R9 chain d1 w1", rd(32'h404), 32'h1111_0001);
        eq("R9 chain d2 w0", rd(32'h480), 32'h2222_0000);
        eq("R3 sh_info d2", sh_info, 32'h111);
        eq("R8 irq set", {31'd0, irq}, 32'd1);
        clr();
        eq("R11 irq cleared", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_ignore();
        fill(32'h400, 3, 32'hEEEE_2000);
        put_cb(32'h40, 32'h810, 32'h200, 32'h400, 32'd8, 32'd0, 32'd0);
        run(32'h40);
        eq("R5 zero w0", rd(32'h400), 32'd0);
        eq("R5 zero w1", rd(32'h404), 32'd0);
        eq("R5 w2 untouched", rd(32'h408), 32'hEEEE_2002);
        clr();
        fill(32'h400, 2, 32'hEEEE_3000);
        put_cb(32'h40, 32'h190, 32'h200, 32'h400, 32'd8, 32'd0, 32'd0);
        run(32'h40);
        eq("R6 no write w0", rd(32'h400), 32'hEEEE_3000);
        eq("R6 no write w1", rd(32'h404), 32'hEEEE_3001);
        eq("R6 dst advanced", cur_dst, 32'h408);
        clr();
    endtask

    task automatic t_fixed();
        fill(32'h200, 2, 32'hC000_0000);
        fill(32'h400, 2, 32'hEEEE_4000);
        put_cb(32'h40, 32'h000, 32'h200, 32'h400, 32'd8, 32'd0, 32'd0);
        run(32'h40);
        eq("R4 fixed dst", rd(32'h400), 32'hC000_0000);
        eq("R4 fixed dst+4 untouched", rd(32'h404), 32'hEEEE_4001);
        eq("R4 fixed src", cur_src, 32'h200);
        clr();
    endtask

    task automatic t_2d();
        fill(32'h200, 8, 32'h5000_0000);
        fill(32'h410, 6, 32'hEEEE_5000);
        put_cb(32'h40, 32'h112, 32'h200, 32'h420, 32'h0002_0008, 32'hFFE8_0008, 32'd0);
        run(32'h40);
        eq("R7 row0 w0", rd(32'h420), 32'h5000_0000);
        eq("R7 row0 w1", rd(32'h424), 32'h5000_0001);
        eq("R7 row1 w0", rd(32'h410), 32'h5000_0004);
        eq("R7 row1 w1", rd(32'h414), 32'h5000_0005);
        eq("R7 gap untouched", rd(32'h418), 32'hEEEE_5002);
        eq("R7 final src", cur_src, 32'h218);
        eq("R7 final dst", cur_dst, 32'h418);
        clr();
    endtask

    task automatic t_round();
        fill(32'h200, 3, 32'h6000_0000);
        fill(32'h400, 3, 32'hEEEE_6000);
        put_cb(32'h40, 32'h110, 32'h200, 32'h400, 32'd6, 32'd0, 32'd0);
        run(32'h40);
        eq("R4 partial w1", rd(32'h404), 32'h6000_0001);
        eq("R4 partial w2 untouched", rd(32'h408), 32'hEEEE_6002);
        clr();
    endtask

    task automatic t_zero();
        run(32'd0);
        eq("R10 zero active", {31'd0, active}, 32'd0);
        eq("R10 zero paused", {31'd0, paused}, 32'd1);
        eq("R10 zero no end", {31'd0, end_flag}, 32'd0);
        clr();
    endtask

    task automatic t_endrop();
        fill(32'h200, 4, 32'h7000_0000);
        fill(32'h400, 4, 32'hEEEE_7000);
        fill(32'h480, 1, 32'hEEEE_7100);
        put_cb(32'h40, 32'h110, 32'h200, 32'h400, 32'd16, 32'd0, 32'h60);
        put_cb(32'h60, 32'h110, 32'h200, 32'h480, 32'd4, 32'd0, 32'd0);
        kick(32'h40);
        repeat (3) @(negedge clk);
        chan_en = 1'b0;
        for (int i = 0; i < 4000 && active; i++) @(negedge clk);
        @(negedge clk);
        eq("R9 d1 completed", rd(32'h40C), 32'h7000_0003);
        eq("R9 d2 not run", rd(32'h480), 32'hEEEE_7100);
        eq("R9 cur_cb is link", cur_cb, 32'h60);
        eq("R10 paused", {31'd0, paused}, 32'd1);
        chan_en = 1'b1;
        clr();
    endtask

    task automatic t_chreset();
        bit seen = 0;
        fill(32'h200, 16, 32'h8000_0000);
        fill(32'h400, 16, 32'hEEEE_8000);
        put_cb(32'h40, 32'h110, 32'h200, 32'h400, 32'd64, 32'd0, 32'd0);
        kick(32'h40);
        repeat (20) @(negedge clk);
        chan_reset = 1'b1;
        @(negedge clk);
        chan_reset = 1'b0;
        eq("R11 active", {31'd0, active}, 32'd0);
        eq("R11 mem_req", {31'd0, mem_req}, 32'd0);
        eq("R11 end_flag", {31'd0, end_flag}, 32'd0);
        eq("R11 cur_cb", cur_cb, 32'd0);
        for (int i = 0; i < 40; i++) begin
            if (mem_req) seen = 1;
            @(negedge clk);
        end
        eq("R11 stays idle", {31'd0, seen}, 32'd0);
        eq("R11 last word untouched", rd(32'h43C), 32'hEEEE_800F);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_single();
        t_chain();
        t_ignore();
        t_fixed();
        t_2d();
        t_round();
        t_zero();
        t_endrop();
        t_chreset();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule